// File: doc/BRIEF.md
# Unsigned Vector Shift-Right-Immediate Unit

This unit executes one instruction class of a SIMD datapath: an unsigned logical shift right of every lane of a 128-bit source vector by an amount carried in the instruction word. It receives the 32-bit instruction together with the source vector and returns the shifted vector, the destination register index and a flag that marks the word as undefined. Register reads and writes happen outside the unit.

A single 7-bit immediate encodes both the lane size and the shift. The highest set bit of its upper four bits picks a lane of 8, 16, 32 or 64 bits. The shift is twice the lane width minus the full 7-bit value, which gives a shift from 1 up to the lane width. The unit decodes a vector form, which works on 64 or 128 bits of data, and a scalar form, which always works on one 64-bit lane. Lanes are shifted independently and zero-filled from the top.

Inputs are captured when `in_valid` is high. The result appears one clock later together with `out_valid`.

Top module: `ushr_unit`

## Requirements
- R1: A word is a vector-form operation when bit 31=0, bit 29=1, bit 28=0, bits 27:23=11110 and bits 15:10=000001. It is a scalar-form operation when bits 31:30=01, bits 29:28=11, bits 27:23=11110 and bits 15:10=000001. `dest_idx` carries bits 4:0 of the captured word.
- R2: In the vector form the lane width comes from the 4-bit field at bits 22:19 (the size field). A highest set bit at position 0, 1, 2 or 3 gives 8, 16, 32 or 64 bits.
- R3: The shift equals 2×lane width minus the unsigned value of bits 22:16. Every lane is shifted right as an unsigned value, is zero-filled from the top and is truncated without rounding.
- R4: A shift equal to the lane width yields an all-zero lane.
- R5: Bit 30 selects 128-bit data when 1 and 64-bit data when 0. With 64-bit data, result bits 127:64 are zero.
- R6: The scalar form shifts one 64-bit lane and zeroes bits 127:64. If the size field has bit 3 clear, the word is undefined.
- R7: The word is undefined when it matches neither form, when the vector form has a size field of 0000, or when the vector form has size bit 3 set with bit 30 clear.
- R8: When the undefined flag is set, the result is all zero.
- R9: `out_valid` is high exactly one clock after a cycle with `in_valid` high. With no new valid input, `out_valid` goes low.
- R10: A synchronous active-high `rst` clears `out_valid`, `result`, `dest_idx` and `undef`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for insn and src |
| insn | input | 32 | Instruction word |
| src | input | 128 | Source vector |
| out_valid | output | 1 | Registered result is valid |
| result | output | 128 | Shifted vector |
| dest_idx | output | 5 | Destination register index |
| undef | output | 1 | Word is not a legal form of the operation |

## Verification
The bench builds the unit with its default 128-bit vector width. At that width every lane size has an instance: sixteen 8-bit, eight 16-bit, four 32-bit and two 64-bit lanes. This makes lane independence, the upper-half zeroing at 64-bit data width and the 64-bit scalar lane all observable. The full-width shift case and each reserved size/width combination are driven on this same build.

// File: rtl/ushr_pkg.sv
package ushr_pkg;
    localparam int INSN_W   = 32;
    localparam int IDX_W    = 5;
    localparam int N_SIZES  = 4;
    localparam int SHAMT_W  = 8;

    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_H16 = 2'd1,
        LANE_S32 = 2'd2,
        LANE_D64 = 2'd3
    } lane_sz_e;
endpackage

// File: rtl/ushr_decode.sv
module ushr_decode
    import ushr_pkg::*;
(
    input  logic [INSN_W-1:0]  insn,
    output logic               bad_word,
    output lane_sz_e           lane_sz,
    output logic [SHAMT_W-1:0] shamt,
    output logic               wide,
    output logic [IDX_W-1:0]   rd_idx
);
    logic [3:0] sz_field;
    logic [6:0] imm7;
    logic       vec_hit;
    logic       scl_hit;
    logic       unused_rn;

    assign unused_rn = ^insn[9:5];

    always_comb begin
        sz_field = insn[22:19];
        imm7     = insn[22:16];
        rd_idx   = insn[4:0];
        vec_hit  = (insn[31] == 1'b0) && (insn[29:28] == 2'b10) &&
                   (insn[27:23] == 5'b11110) && (insn[15:10] == 6'b000001);
        scl_hit  = (insn[31:30] == 2'b01) && (insn[29:28] == 2'b11) &&
                   (insn[27:23] == 5'b11110) && (insn[15:10] == 6'b000001);

        casez (sz_field)
            4'b1???: lane_sz = LANE_D64;
            4'b01??: lane_sz = LANE_S32;
            4'b001?: lane_sz = LANE_H16;
            default: lane_sz = LANE_B8;
        endcase

        shamt = (SHAMT_W'(16) << lane_sz) - {1'b0, imm7};
        wide  = vec_hit && insn[30];

        bad_word = !(vec_hit || scl_hit)
                 || (vec_hit && (sz_field == 4'b0000))
                 || (vec_hit && sz_field[3] && !insn[30])
                 || (scl_hit && !sz_field[3]);
    end
endmodule

// File: rtl/ushr_lane_shift.sv
module ushr_lane_shift
    import ushr_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int VEC_W  = 128
) (
    input  logic [VEC_W-1:0]   src,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [VEC_W-1:0]   res
);
    localparam int                 N_LANES = VEC_W / LANE_W;
    localparam logic [SHAMT_W-1:0] LANE_LIM = SHAMT_W'(LANE_W);

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic [LANE_W-1:0] lane_in;
        assign lane_in = src[i*LANE_W +: LANE_W];
        // full-width shift must clear the lane
        assign res[i*LANE_W +: LANE_W] =
            (shamt >= LANE_LIM) ? '0 : (lane_in >> shamt);
    end
endmodule

// File: rtl/ushr_unit.sv
module ushr_unit
    import ushr_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       insn,
    input  logic [VEC_W-1:0]  src,
    output logic              out_valid,
    output logic [VEC_W-1:0]  result,
    output logic [4:0]        dest_idx,
    output logic              undef
);
    localparam int HALF_W = VEC_W / 2;

    typedef struct packed {
        logic             valid;
        logic             undef;
        logic [IDX_W-1:0] rd;
        logic [VEC_W-1:0] data;
    } out_reg_t;

    out_reg_t out_d, out_q;

    logic               dec_bad;
    lane_sz_e           dec_sz;
    logic [SHAMT_W-1:0] dec_shamt;
    logic               dec_wide;
    logic [IDX_W-1:0]   dec_rd;
    logic [VEC_W-1:0]   shifted [N_SIZES];
    logic [VEC_W-1:0]   keep_mask;

    ushr_decode u_dec (
        .insn     (insn),
        .bad_word (dec_bad),
        .lane_sz  (dec_sz),
        .shamt    (dec_shamt),
        .wide     (dec_wide),
        .rd_idx   (dec_rd)
    );

    for (genvar s = 0; s < N_SIZES; s++) begin : g_size
        ushr_lane_shift #(
            .LANE_W (8 << s),
            .VEC_W  (VEC_W)
        ) u_shift (
            .src   (src),
            .shamt (dec_shamt),
            .res   (shifted[s])
        );
    end

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid;
        keep_mask   = dec_wide ? {VEC_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        if (in_valid) begin
            out_d.rd    = dec_rd;
            out_d.undef = dec_bad;
            out_d.data  = dec_bad ? '0 : (shifted[dec_sz] & keep_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign out_valid = out_q.valid;
    assign result    = out_q.data;
    assign dest_idx  = out_q.rd;
    assign undef     = out_q.undef;

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !$past(rst)) |=> out_valid);
    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_rd_capture_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (dest_idx == $past(insn[4:0])));
    assert_undef_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && undef) |-> (result == '0));
    assert_narrow_upper_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dec_wide) |=> (result[VEC_W-1:HALF_W] == '0));
    assert_reserved_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !insn[31] && insn[30] == 1'b0 && insn[22] && insn[29:28] == 2'b10
         && insn[27:23] == 5'b11110 && insn[15:10] == 6'b000001) |=> undef);
    assert_full_shift_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !dec_bad && dec_shamt == (SHAMT_W'(8) << dec_sz)) |=> (result == '0));
endmodule

// File: tb/ushr_unit_test.sv
module ushr_unit_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [31:0]  insn;
    logic [127:0] src;
    logic         out_valid;
    logic [127:0] result;
    logic [4:0]   dest_idx;
    logic         undef;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ushr_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .src(src),
        .out_valid(out_valid), .result(result), .dest_idx(dest_idx), .undef(undef)
    );

    // kind: 0 vector, 1 scalar, 2 malformed (bit 10 cleared)
    typedef struct packed {
        logic [1:0]   kind;
        logic         q;
        logic [3:0]   immh;
        logic [2:0]   immb;
        logic [127:0] s;
        logic [127:0] exp;
        logic         exp_undef;
    } vec_t;

    localparam logic [127:0] ONES = {128{1'b1}};
    localparam logic [127:0] PAT  = 128'h12345678_9ABCDEF0_0FEDCBA9_87654321;
    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 1'b1, 4'b0001, 3'b111, ONES, {16{8'h7F}}, 1'b0},                         // R2 R3 8-bit shift 1
        '{2'd0, 1'b1, 4'b0001, 3'b000, ONES, 128'h0, 1'b0},                               // R4 8-bit shift 8
        '{2'd0, 1'b1, 4'b0010, 3'b100, ONES, {8{16'h000F}}, 1'b0},                        // R2 16-bit shift 12
        '{2'd0, 1'b0, 4'b0100, 3'b001, ONES, {64'h0, 32'h1, 32'h1}, 1'b0},                // R5 32-bit shift 31
        '{2'd0, 1'b1, 4'b1000, 3'b000, ONES, 128'h0, 1'b0},                               // R4 64-bit shift 64
        '{2'd0, 1'b1, 4'b1111, 3'b111, ONES, {2{64'h7FFFFFFF_FFFFFFFF}}, 1'b0},           // R2 64-bit shift 1
        '{2'd0, 1'b0, 4'b1000, 3'b010, ONES, 128'h0, 1'b1},                               // R7 reserved 64/Q0
        '{2'd0, 1'b1, 4'b0000, 3'b101, ONES, 128'h0, 1'b1},                               // R7 size 0000
        '{2'd1, 1'b1, 4'b1000, 3'b100, ONES, {64'h0, 64'hF}, 1'b0},                       // R6 scalar shift 60
        '{2'd1, 1'b1, 4'b0111, 3'b000, ONES, 128'h0, 1'b1},                               // R6 scalar bad size
        '{2'd2, 1'b1, 4'b0010, 3'b100, ONES, 128'h0, 1'b1},                               // R7 no match
        '{2'd0, 1'b1, 4'b0011, 3'b100, PAT,
          128'h0123_0567_09AB_0DEF_00FE_0CBA_0876_0432, 1'b0},                            // R3 16-bit shift 4
        '{2'd0, 1'b1, 4'b0111, 3'b000, PAT,
          128'h00123456_009ABCDE_000FEDCB_00876543, 1'b0},                                // R3 32-bit shift 8
        '{2'd0, 1'b0, 4'b0001, 3'b101, PAT, {64'h0, 64'h011D1915_100C0804}, 1'b0}        // R5 8-bit Q0 shift 3
    };

    function automatic logic [31:0] mk(input vec_t v, input logic [4:0] rd);
        logic [31:0] w;
        if (v.kind == 2'd1)
            w = {2'b01, 2'b11, 5'b11110, v.immh, v.immb, 6'b000001, 5'd7, rd};
        else
            w = {1'b0, v.q, 2'b10, 5'b11110, v.immh, v.immb, 6'b000001, 5'd7, rd};
        if (v.kind == 2'd2) w[10] = 1'b0;
        return w;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; insn = '0; src = '0;
        repeat (3) @(negedge clk);
        check("R10 out_valid", 128'(out_valid), 128'h0);
        check("R10 result", result, 128'h0);
        check("R10 dest_idx/undef", {dest_idx, undef}, 128'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            insn     = mk(TBL[i], 5'(i + 3));
            src      = TBL[i].s;
            @(negedge clk);
            in_valid = 1'b0;
            insn     = '0;
            check($sformatf("R9 valid case %0d", i), 128'(out_valid), 128'h1);
            check($sformatf("R1 rd case %0d", i), 128'(dest_idx), 128'(i + 3));
            check($sformatf("R7 undef case %0d", i), 128'(undef), 128'(TBL[i].exp_undef));
            check($sformatf("R3 R8 result case %0d", i), result, TBL[i].exp);
        end

        @(negedge clk);
        check("R9 valid drops", 128'(out_valid), 128'h0);

        // R10: reset after a valid result clears everything
        in_valid = 1'b1; insn = mk(TBL[0], 5'd21); src = ONES;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        check("R10 reset clears valid", 128'(out_valid), 128'h0);
        check("R10 reset clears data", {result, dest_idx, undef} == '0 ? 128'h0 : 128'h1, 128'h0);
        rst = 1'b0;

        // R9: valid in during reset then released gives no stray valid after idle
        @(negedge clk);
        check("R9 idle after reset", 128'(out_valid), 128'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule